// File: doc/BRIEF.md
# Iterative Substitution-Permutation Block Encryptor

This block encrypts one 128-bit block at a time. It has a single state register, a multiplexer in front of it, and one combinational round. When the block is idle and the caller asserts `in_valid`, the block is loaded. Each of the next 32 clock cycles then evaluates one round. A round XORs in the key for the current round, then passes every 4-bit nibble through a substitution table, then applies a fixed linear mixing step.

Eight different substitution layers are built side by side. The low three bits of the round counter pick which layer's result is used. After the final round, a separate final key is XORed into the state. The result then appears for one cycle with `out_valid`.

Round keys come from outside the block. `rk_idx` publishes the round number, and the key source must present the matching key on `rk` in the same cycle. The final key is held on `fin_key`.

Top module: `spn_iter_enc`

## Requirements
- R1: While idle (`in_ready` high), a cycle with `in_valid` high loads `in_block` into the state. In the next cycle `rk_idx` is 0 and `in_ready` is low.
- R2: One round is evaluated per clock cycle. While busy, `rk_idx` steps 0, 1, ..., 31, one step per cycle, and the key on `rk` is used in that same cycle.
- R3: `out_valid` is high in the cycle after the 32nd round edge. That is 32 rising edges after the accepting edge.
- R4: The round with index r uses substitution layer r mod 8. The table parameter is packed so that entry k, bits [4v+3:4v], hold S_k(v). The default tables are S_k(v) = ((2k+3)·v + 5k + 1) mod 16, with each product taken mod 16. All 32 nibbles of the state use the same S_k.
- R5: While busy, `in_ready` is low and `in_valid` is ignored. A block offered during a run does not change the result of that run, and it produces no extra result.
- R6: `out_valid` is high for exactly one cycle per accepted block.
- R7: A round is computed in three steps. First x = s XOR rk. Then every nibble of x is substituted. Finally, with y the substituted value, the output is y XOR rotl(y,13) XOR rotl(y,71), where rotl is a rotation toward the MSB.
- R8: `fin_key` is XORed into the state after the last round's linear step. `out_block` holds this value while `out_valid` is high.
- R9: After reset, `in_ready` is high, `out_valid` is low and `rk_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Offer of a new block |
| in_ready | output | 1 | High when a new block can be taken |
| in_block | input | 128 | Plaintext block |
| rk_idx | output | 5 | Index of the round key needed this cycle |
| rk | input | 128 | Round key for round `rk_idx` |
| fin_key | input | 128 | Key XORed after the last round |
| out_valid | output | 1 | One-cycle result strobe |
| out_block | output | 128 | Ciphertext block |

## Verification
The assertions assume that `rk` follows `rk_idx` combinationally, within the same cycle. They also assume that `fin_key` is steady for the whole run. Neither assumption can be checked from inside the block, so only control sequencing and state holding are asserted.

The stimulus meets these assumptions by driving `rk` as a lookup of `rk_idx` into a key array. The key array and `fin_key` are rewritten only while the block is idle. Offers made during a run use junk data, and the bench expects them to leave the run's result untouched.

// File: rtl/spn_pkg.sv
package spn_pkg;
  localparam int BLK_W   = 128;
  localparam int NIB_W   = 4;
  localparam int N_NIB   = BLK_W / NIB_W;
  localparam int N_VAR   = 8;
  localparam int TAB_W   = NIB_W * (1 << NIB_W);
  localparam int ROT_A   = 13;
  localparam int ROT_B   = 71;

  typedef logic [N_VAR-1:0][TAB_W-1:0] sbox_set_t;

  // one affine nibble permutation, odd multiplier keeps it bijective
  function automatic logic [TAB_W-1:0] affine_perm(input int mul, input int add);
    logic [TAB_W-1:0] t;
    t = '0;
    for (int v = 0; v < (1 << NIB_W); v++)
      t[v*NIB_W +: NIB_W] = NIB_W'((mul * v + add) % (1 << NIB_W));
    return t;
  endfunction

  function automatic sbox_set_t default_sboxes();
    sbox_set_t s;
    for (int k = 0; k < N_VAR; k++)
      s[k] = affine_perm((2*k + 3) % 16, (5*k + 1) % 16);
    return s;
  endfunction

  function automatic logic [NIB_W-1:0] nib_lookup(input logic [TAB_W-1:0] tab,
                                                  input logic [NIB_W-1:0] v);
    return tab[v*NIB_W +: NIB_W];
  endfunction

  function automatic logic [BLK_W-1:0] rotl(input logic [BLK_W-1:0] x, input int n);
    return (x << n) | (x >> (BLK_W - n));
  endfunction

  // three-term rotation XOR: odd term count makes it invertible
  function automatic logic [BLK_W-1:0] lin_mix(input logic [BLK_W-1:0] y);
    return y ^ rotl(y, ROT_A) ^ rotl(y, ROT_B);
  endfunction
endpackage

// File: rtl/spn_sbox_layer.sv
module spn_sbox_layer
  import spn_pkg::*;
#(
  parameter logic [TAB_W-1:0] TAB = '0
) (
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  for (genvar n = 0; n < N_NIB; n++) begin : g_nib
    assign dout[n*NIB_W +: NIB_W] = nib_lookup(TAB, din[n*NIB_W +: NIB_W]);
  end
endmodule

// File: rtl/spn_round.sv
module spn_round
  import spn_pkg::*;
#(
  parameter sbox_set_t SBOXES = default_sboxes(),
  localparam int SEL_W = $clog2(N_VAR)
) (
  input  logic [BLK_W-1:0] state,
  input  logic [BLK_W-1:0] rkey,
  input  logic [SEL_W-1:0] sel,
  output logic [BLK_W-1:0] nxt
);
  logic [BLK_W-1:0] mixed;
  logic [BLK_W-1:0] lay_out [N_VAR];
  logic [N_VAR-1:0] sel_oh;
  logic [BLK_W-1:0] subst;

  assign mixed = state ^ rkey;

  for (genvar k = 0; k < N_VAR; k++) begin : g_var
    spn_sbox_layer #(.TAB(SBOXES[k])) u_lay (.din(mixed), .dout(lay_out[k]));
    assign sel_oh[k] = (sel == SEL_W'(k));
  end

  always_comb begin
    subst = '0;
    for (int k = 0; k < N_VAR; k++)
      subst = subst | (lay_out[k] & {BLK_W{sel_oh[k]}});
  end

  assign nxt = lin_mix(subst);
endmodule

// File: rtl/spn_ctrl.sv
module spn_ctrl #(
  parameter int ROUNDS = 32,
  localparam int CNT_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             load,
  output logic             busy,
  output logic             last,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  assign in_ready = !busy_q;
  assign load     = in_valid && !busy_q;
  assign last     = busy_q && (cnt_q == CNT_W'(ROUNDS - 1));
  assign busy     = busy_q;
  assign cnt      = cnt_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        busy_q <= !last;
        cnt_q  <= last ? '0 : cnt_q + 1'b1;
      end
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy_q && cnt_q == '0); // R1
  AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> busy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done_q && !busy_q); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && in_valid && !last) |=> cnt_q != '0); // R5
endmodule

// File: rtl/spn_iter_enc.sv
module spn_iter_enc
  import spn_pkg::*;
#(
  parameter int        ROUNDS = 32,
  parameter sbox_set_t SBOXES = default_sboxes(),
  localparam int CNT_W = $clog2(ROUNDS),
  localparam int SEL_W = $clog2(N_VAR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_block,
  output logic [CNT_W-1:0] rk_idx,
  input  logic [BLK_W-1:0] rk,
  input  logic [BLK_W-1:0] fin_key,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_block
);
  logic             load, busy, last, done;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] state_q, rnd_nxt;

  spn_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .busy(busy), .last(last), .cnt(cnt), .done(done)
  );

  spn_round #(.SBOXES(SBOXES)) u_round (
    .state(state_q), .rkey(rk), .sel(cnt[SEL_W-1:0]), .nxt(rnd_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= '0;
    else if (load) state_q <= in_block;
    else if (busy) state_q <= last ? (rnd_nxt ^ fin_key) : rnd_nxt;
  end

  assign rk_idx    = cnt;
  assign out_valid = done;
  assign out_block = state_q;

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(state_q)); // R5
  AST_LOAD_TAKES_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state_q == $past(in_block)); // R1
endmodule

// File: tb/tb_spn_iter_enc.sv
`timescale 1ns/1ps
module tb_spn_iter_enc;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic         in_ready;
  logic [127:0] in_block = '0;
  logic [4:0]   rk_idx;
  logic [127:0] rk;
  logic [127:0] fin_key = '0;
  logic         out_valid;
  logic [127:0] out_block;

  logic [127:0] keys [32];
  logic [127:0] expq [$];
  int n_chk = 0, n_bad = 0, n_out = 0;

  always #2.5 clk = ~clk;

  assign rk = keys[rk_idx];

  spn_iter_enc dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .rk_idx(rk_idx), .rk(rk), .fin_key(fin_key),
    .out_valid(out_valid), .out_block(out_block));

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [3:0] ref_sub(input int var_i, input logic [3:0] v);
    int m, c;
    m = (3 + 2*var_i) & 15;
    c = (1 + 5*var_i) & 15;
    return 4'((m * int'(v) + c) & 15);
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] blk);
    logic [127:0] s, y;
    s = blk;
    for (int r = 0; r < 32; r++) begin
      s = s ^ keys[r];
      for (int n = 0; n < 32; n++) y[4*n +: 4] = ref_sub(r % 8, s[4*n +: 4]);
      s = y ^ {y[114:0], y[127:115]} ^ {y[56:0], y[127:57]};
    end
    return s ^ fin_key;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected results as the design produces them (R8, R7, R4)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_out++;
      if (expq.size() == 0) chk(1'b0, "R5 extra result", out_block, '0);
      else begin
        logic [127:0] e;
        e = expq.pop_front();
        chk(out_block == e, "R8 result", out_block, e);
      end
    end
  end

  task automatic run_block(input logic [127:0] blk, input bit poke);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_block = blk;
    expq.push_back(ref_enc(blk));
    @(posedge clk);
    #1 in_valid = 0; in_block = rnd128();
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      chk(rk_idx == 5'(r), "R2 rk_idx", 128'(rk_idx), 128'(r));
      chk(!in_ready, "R5 ready low", 128'(in_ready), 0);
      if (poke && r == 4) in_valid = 1;
      if (poke && r == 6) in_valid = 0;
    end
    @(negedge clk);
    chk(out_valid, "R3 latency", 128'(out_valid), 1);
    @(negedge clk);
    chk(!out_valid, "R6 pulse", 128'(out_valid), 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) keys[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(in_ready, "R9 ready", 128'(in_ready), 1);
    chk(!out_valid, "R9 valid", 128'(out_valid), 0);
    chk(rk_idx == 0, "R9 rk_idx", 128'(rk_idx), 0);
    // R1/R7: all-zero keys and block, substitution and mixing alone
    run_block('0, 0);
    // R8: only final key set
    fin_key = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
    run_block('0, 0);
    // R4: distinct key per round, layer varies with round
    for (int i = 0; i < 32; i++) keys[i] = {4{32'(i * 32'h01010101)}};
    run_block(128'h0123456789ABCDEF0011223344556677, 0);
    // R5: offers during a run are ignored
    run_block(rnd128(), 1);
    for (int t = 0; t < 16; t++) begin
      for (int i = 0; i < 32; i++) keys[i] = rnd128();
      fin_key = rnd128();
      run_block(rnd128(), t % 3 == 0);
    end
    // R6: back-to-back offer right after the strobe
    run_block('1, 0);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R5 queue drained", 128'(expq.size()), 0);
    chk(n_out == 21, "R6 result count", 128'(n_out), 21);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule